// File: doc/BRIEF.md
# Expansion Bus Device Select Decoder

This block is the glue logic of a peripheral card on the expansion bus of an 8-bit host with a 6502-style bus. The host switches each card on or off by writing one byte to a shared device-select register at 0xD1FF. Each card watches one bit of that byte, chosen by a static 3-bit strap, so up to eight cards can share the bus. The block keeps its own enable flag. The flag is loaded from the chosen data bit when the PHI2 high phase of a write to the register ends. A system reset clears it.

While the flag is set, the block takes over the 2 KB window 0xD800..0xDFFF from the host's built-in firmware ROM on read cycles. It drives the built-in-ROM disable, the external-select, and its own ROM's chip-select and output-enable, all active low. It also gives an active-low select for the card's private I/O registers at 0xD1F0..0xD1FE. All selects are combinational from the live bus and are qualified by PHI2 high. The block runs from a fast system clock. It samples PHI2 on that clock to find the end of each bus cycle, so each write commits exactly once.

Top module: `exp_dev_select`

## Requirements
- R1: A write cycle (rdNwr=0) to address 0xD1FF loads devOn from data bit dataIn[bitSel]. A write to any other address, and any read cycle, leaves devOn unchanged.
- R2: bitSel (0..7) names the one data-bus bit the card responds to. The other seven bits of the written byte have no effect on devOn.
- R3: The write is committed on the first rising clk edge at which phi2 is sampled low after being sampled high. devOn changes on that edge and on no other edge.
- R4: rstN low clears devOn at once, without waiting for a clock edge. With devOn clear, all five active-low selects stay high.
- R5: When devOn=1, phi2=1, rdNwr=1 and addr is in 0xD800..0xDFFF, the outputs romDisN, extSelN, romCsN and romOeN are all low in the same cycle.
- R6: romDisN, extSelN, romCsN and romOeN are all high whenever devOn=0, phi2=0, rdNwr=0, or addr is outside 0xD800..0xDFFF. This covers write cycles into the window.
- R7: ioSelN is low exactly when devOn=1, phi2=1 and addr is in 0xD1F0..0xD1FE, on read and write cycles alike. It is high at 0xD1FF and below 0xD1F0.
- R8: A write to 0xD1FF with the chosen bit at 0 clears a set devOn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that samples the bus |
| rstN | input | 1 | System reset, active low, asynchronous |
| phi2 | input | 1 | Bus phase clock; the bus is valid while it is high |
| addr | input | 16 | Host address bus |
| dataIn | input | 8 | Host data bus |
| rdNwr | input | 1 | Bus direction: 1 = read, 0 = write |
| bitSel | input | 3 | Static strap choosing this card's data bit |
| romDisN | output | 1 | Built-in ROM disable, active low |
| extSelN | output | 1 | External select, active low |
| romCsN | output | 1 | Card ROM chip select, active low |
| romOeN | output | 1 | Card ROM output enable, active low |
| ioSelN | output | 1 | Private I/O range select, active low |
| devOn | output | 1 | Enable flag state |

## Verification
The enable path is exercised with three kinds of write:
- Bytes with only the chosen bit set, which shows the bit is taken from the right lane.
- Bytes with every bit set except the chosen one, which shows the other lanes are ignored.
- Bytes written to the neighbouring address 0xD1FE, which shows the full address is decoded.

The ROM overlay is probed at both edges of the window and one address outside each edge. It is also probed with the flag clear, with PHI2 low, and on a write cycle; these three separate the enable, phase and direction qualifiers. The I/O select is probed at both ends of its range, at the register address itself and just below the range, in both directions. The commit point is checked by holding PHI2 high over several clocks and confirming the flag moves only after PHI2 falls.

// File: rtl/exp_dev_pkg.sv
package exp_dev_pkg;

  // Strobes passed from the bus control to the datapath
  typedef struct packed {
    logic sample;    // bus phase active: capture bus state
    logic regWrite;  // write cycle addressed to the select register
    logic commit;    // end of a bus cycle (phi2 fell)
    logic romRead;   // read cycle inside the overlay window
    logic ioAccess;  // access inside the private I/O range
  } ctlStrobes_t;

endpackage

// File: rtl/exp_dev_ctl.sv
module exp_dev_ctl
  import exp_dev_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int REG_ADDR = 'hD1FF,
  parameter int ROM_BASE = 'hD800,
  parameter int ROM_AW   = 11,
  parameter int IO_BASE  = 'hD1F0,
  parameter int IO_AW    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phi2,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdNwr,
  output ctlStrobes_t       stb
);

  localparam logic [ADDR_W-1:0] regAddrV = ADDR_W'(REG_ADDR);
  localparam logic [ADDR_W-1:0] romBaseV = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W-1:0] ioBaseV  = ADDR_W'(IO_BASE);

  logic phi2Q;
  logic regHit;
  logic romHit;
  logic ioHit;

  // Previous phi2 sample for fall detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phi2Q <= 1'b0;
    else       phi2Q <= phi2;
  end

  assign regHit = (addr == regAddrV);
  assign romHit = (addr[ADDR_W-1:ROM_AW] == romBaseV[ADDR_W-1:ROM_AW]);
  assign ioHit  = (addr[ADDR_W-1:IO_AW] == ioBaseV[ADDR_W-1:IO_AW]) && !regHit;

  always_comb begin
    stb.sample   = phi2;
    stb.regWrite = phi2 && !rdNwr && regHit;
    stb.commit   = phi2Q && !phi2;
    stb.romRead  = phi2 && rdNwr && romHit;
    stb.ioAccess = phi2 && ioHit;
  end

endmodule

// File: rtl/exp_dev_dp.sv
module exp_dev_dp
  import exp_dev_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [SEL_W-1:0]  bitSel,
  output logic              romDisN,
  output logic              extSelN,
  output logic              romCsN,
  output logic              romOeN,
  output logic              ioSelN,
  output logic              devOn
);

  logic [DATA_W-1:0] dataQ;
  logic              wrPend;
  logic              romTake;

  // Bus state is captured while phi2 is high and committed when it falls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      wrPend <= 1'b0;
      devOn  <= 1'b0;
    end else if (stb.commit) begin
      if (wrPend) devOn <= dataQ[bitSel];
      wrPend <= 1'b0;
    end else if (stb.sample) begin
      dataQ  <= dataIn;
      wrPend <= stb.regWrite;
    end
  end

  assign romTake = devOn && stb.romRead;

  always_comb begin
    romDisN = !romTake;
    extSelN = !romTake;
    romCsN  = !romTake;
    romOeN  = !romTake;
    ioSelN  = !(devOn && stb.ioAccess);
  end

endmodule

// File: rtl/exp_dev_select.sv
module exp_dev_select
  import exp_dev_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int REG_ADDR = 'hD1FF,
  parameter int ROM_BASE = 'hD800,
  parameter int ROM_AW   = 11,
  parameter int IO_BASE  = 'hD1F0,
  parameter int IO_AW    = 4,
  localparam int SEL_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phi2,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdNwr,
  input  logic [SEL_W-1:0]  bitSel,
  output logic              romDisN,
  output logic              extSelN,
  output logic              romCsN,
  output logic              romOeN,
  output logic              ioSelN,
  output logic              devOn
);

  ctlStrobes_t stb;

  exp_dev_ctl #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .ROM_BASE(ROM_BASE),
    .ROM_AW(ROM_AW), .IO_BASE(IO_BASE), .IO_AW(IO_AW)
  ) ctlI (
    .clk(clk), .rstN(rstN), .phi2(phi2), .addr(addr), .rdNwr(rdNwr), .stb(stb)
  );

  exp_dev_dp #(.DATA_W(DATA_W)) dpI (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn), .bitSel(bitSel),
    .romDisN(romDisN), .extSelN(extSelN), .romCsN(romCsN), .romOeN(romOeN),
    .ioSelN(ioSelN), .devOn(devOn)
  );

endmodule

// File: rtl/exp_dev_select_chk.sv
module exp_dev_select_chk (
  input logic        clk,
  input logic        rstN,
  input logic        phi2,
  input logic [15:0] addr,
  input logic        rdNwr,
  input logic        romDisN,
  input logic        extSelN,
  input logic        romCsN,
  input logic        romOeN,
  input logic        ioSelN,
  input logic        devOn
);

  // R4
  always @(posedge clk) begin
    if (!rstN) begin
      reset_clear_chk: assert (!devOn && ioSelN && romCsN);
    end
  end

  // R5
  rom_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devOn && phi2 && rdNwr && addr[15:11] == 5'h1B)
      |-> (!romDisN && !extSelN && !romCsN && !romOeN));

  // R6
  rom_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!devOn || !phi2 || !rdNwr || addr[15:11] != 5'h1B)
      |-> (romDisN && extSelN && romCsN && romOeN));

  // R7
  io_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!devOn || !phi2 || addr[15:4] != 12'hD1F || addr[3:0] == 4'hF) |-> ioSelN);

  // R3
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devOn) |-> ($past(phi2, 2) && !$past(phi2)));

endmodule

bind exp_dev_select exp_dev_select_chk chkI (
  .clk(clk), .rstN(rstN), .phi2(phi2), .addr(addr), .rdNwr(rdNwr),
  .romDisN(romDisN), .extSelN(extSelN), .romCsN(romCsN), .romOeN(romOeN),
  .ioSelN(ioSelN), .devOn(devOn)
);

// File: tb/exp_dev_select_test.sv
module exp_dev_select_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phi2 = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic        rdNwr = 1'b1;
  logic [2:0]  bitSel = 3'd3;
  logic        romDisN, extSelN, romCsN, romOeN, ioSelN, devOn;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exp_dev_select uut (
    .clk(clk), .rstN(rstN), .phi2(phi2), .addr(addr), .dataIn(dataIn),
    .rdNwr(rdNwr), .bitSel(bitSel), .romDisN(romDisN), .extSelN(extSelN),
    .romCsN(romCsN), .romOeN(romOeN), .ioSelN(ioSelN), .devOn(devOn)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] romOuts();
    return {romDisN, extSelN, romCsN, romOeN};
  endfunction

  task automatic idle();
    @(negedge clk);
    phi2 = 1'b0; rdNwr = 1'b1; addr = 16'h0000;
  endtask

  task automatic busWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; rdNwr = 1'b0; phi2 = 1'b0;
    @(negedge clk);
    phi2 = 1'b1;
    repeat (3) @(negedge clk);
    phi2 = 1'b0;
    repeat (2) @(negedge clk);
    rdNwr = 1'b1; addr = 16'h0000;
  endtask

  task automatic probe(logic [15:0] a, logic rd, logic ph);
    @(negedge clk);
    addr = a; rdNwr = rd; phi2 = ph;
    #(CLK_PERIOD/4);
  endtask

  task automatic testReset();
    check("R4 devOn after reset", 8'(devOn), 8'h0);
    check("R4 rom outs after reset", 8'(romOuts()), 8'hF);
    check("R4 ioSelN after reset", 8'(ioSelN), 8'h1);
    probe(16'hD800, 1'b1, 1'b1);
    check("R6 rom read while off", 8'(romOuts()), 8'hF);
    probe(16'hD1F0, 1'b1, 1'b1);
    check("R7 io while off", 8'(ioSelN), 8'h1);
    idle();
  endtask

  task automatic testEnable();
    busWrite(16'hD1FF, 8'h08);
    check("R1 enable via bit3", 8'(devOn), 8'h1);
  endtask

  task automatic testRomWindow();
    probe(16'hD800, 1'b1, 1'b1);
    check("R5 window low edge", 8'(romOuts()), 8'h0);
    probe(16'hDFFF, 1'b1, 1'b1);
    check("R5 window high edge", 8'(romOuts()), 8'h0);
    probe(16'hD7FF, 1'b1, 1'b1);
    check("R6 below window", 8'(romOuts()), 8'hF);
    probe(16'hE000, 1'b1, 1'b1);
    check("R6 above window", 8'(romOuts()), 8'hF);
    probe(16'hD900, 1'b0, 1'b1);
    check("R6 write cycle in window", 8'(romOuts()), 8'hF);
    probe(16'hD900, 1'b1, 1'b0);
    check("R6 phi2 low in window", 8'(romOuts()), 8'hF);
    idle();
  endtask

  task automatic testIo();
    probe(16'hD1F0, 1'b1, 1'b1);
    check("R7 io low end", 8'(ioSelN), 8'h0);
    probe(16'hD1FE, 1'b0, 1'b1);
    check("R7 io high end write", 8'(ioSelN), 8'h0);
    probe(16'hD1FF, 1'b1, 1'b1);
    check("R7 register not io", 8'(ioSelN), 8'h1);
    probe(16'hD1EF, 1'b1, 1'b1);
    check("R7 below io", 8'(ioSelN), 8'h1);
    probe(16'hD1F5, 1'b1, 1'b0);
    check("R7 phi2 low io", 8'(ioSelN), 8'h1);
    idle();
  endtask

  task automatic testOtherAddr();
    busWrite(16'hD1FE, 8'h00);
    check("R1 write to other address ignored", 8'(devOn), 8'h1);
    // read of the register never loads the flag
    probe(16'hD1FF, 1'b1, 1'b1);
    dataIn = 8'h00;
    idle();
    repeat (2) @(negedge clk);
    check("R1 read cycle ignored", 8'(devOn), 8'h1);
  endtask

  task automatic testClear();
    busWrite(16'hD1FF, 8'hF7);
    check("R8 clear with bit3 low", 8'(devOn), 8'h0);
    probe(16'hD800, 1'b1, 1'b1);
    check("R6 rom after clear", 8'(romOuts()), 8'hF);
    idle();
  endtask

  task automatic testBitSel();
    bitSel = 3'd6;
    busWrite(16'hD1FF, 8'hBF);
    check("R2 other bits ignored", 8'(devOn), 8'h0);
    busWrite(16'hD1FF, 8'h40);
    check("R2 bit6 selected", 8'(devOn), 8'h1);
  endtask

  task automatic testCommitTiming();
    @(negedge clk);
    addr = 16'hD1FF; dataIn = 8'h00; rdNwr = 1'b0;
    @(negedge clk);
    phi2 = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 held while phi2 high", 8'(devOn), 8'h1);
    phi2 = 1'b0;
    @(negedge clk);
    check("R3 committed after fall", 8'(devOn), 8'h0);
    rdNwr = 1'b1; addr = 16'h0000;
  endtask

  task automatic testResetMid();
    busWrite(16'hD1FF, 8'h40);
    check("R1 re-enable", 8'(devOn), 8'h1);
    #(CLK_PERIOD/4);
    rstN = 1'b0;
    #1;
    check("R4 async clear", 8'(devOn), 8'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnable();
    testRomWindow();
    testIo();
    testOtherAddr();
    testClear();
    testBitSel();
    testCommitTiming();
    testResetMid();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule